// File: doc/BRIEF.md
# Nibble-Configurable Address/IO Port

This block controls an 8-bit bidirectional pad group in a small microcontroller. The group is split into two 4-bit halves. Each half is set on its own to one of three roles: general-purpose input, general-purpose output, or a source of high external-memory address bits. Software picks the roles, and a few global options, through a mode register on a simple register bus. A second register on the same bus holds the data. Software reads the pads through it and writes output values into it.

The role each half takes at power-up comes from a strap. With the strap set for external program memory, both halves start as address outputs carrying the top byte of the address. A slow-memory timing flag is raised at the same time, and software can later drop it. With the strap set for internal program memory, the whole group starts as input. A handshake option ties the lower half's direction to the upper half's. A high-impedance request floats the address-role pins and tells the companion port and the memory strobes to float too.

Top module: `addr_io_port`

## Requirements
- R1: While reset is held and after it is released with `strap_romless`=1, both halves are in address role: `pad_out` equals `mem_addr[15:8]`, `pad_oe` is 8'hFF and `ext_timing` is 1.
- R2: After reset with `strap_romless`=0, both halves are inputs: `pad_oe` is 0, `pad_out` is 0 and `ext_timing` is 0.
- R3: Mode register (`reg_sel`=1) holds the lower-half role in bits [1:0] and the upper-half role in bits [3:2]. The codes are 00 input, 01 output, 10 address, and 11 behaves exactly like input. Reading it returns {hiz request, handshake enable, `ext_timing`, open-drain, upper code, lower code}.
- R4: A lower half in address role drives `mem_addr[11:8]` with all enables on. An upper half in address role drives `mem_addr[15:12]`. The lower half can carry the address while the upper half is input or output.
- R5: A write to the data register (`reg_sel`=0) changes only the halves currently in output role. Those halves drive the stored bits and read back the stored bits.
- R6: Halves not in output role read, through the data register, the `pad_in` value captured at the previous clock edge.
- R7: Writing the mode register with bit 5 set clears `ext_timing`. Bit 5 clear leaves it unchanged, and only reset can raise it again.
- R8: Mode bit 4 selects open-drain globally. An output-role bit at 1 then has its enable off, and a bit at 0 has its enable on while driving 0. With bit 4 clear, output-role enables are all on. Address-role halves are not affected.
- R9: With handshake enabled (mode bit 6) and the upper half not in address role, `hs_active` is 1 and `hs_dir_out` is 1 only for an output-role upper half. A lower half that is not in address role then takes the upper half's role.
- R10: With mode bit 7 set and at least one half in address role, `bus_hiz` is 1 and the address-role halves have all enables off. With no half in address role, `bus_hiz` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_romless | input | 1 | 1 selects external program memory at reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 data register, 1 mode register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| mem_addr | input | ADDR_W | External memory address from the core |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Per-bit pad output enable |
| open_drain | output | 1 | Global open-drain select for the pad drivers |
| ext_timing | output | 1 | Extended memory timing flag |
| hs_active | output | 1 | Handshake control in effect |
| hs_dir_out | output | 1 | Handshake transfer direction, 1 means output |
| bus_hiz | output | 1 | Float companion port and memory strobes |

## Verification
The assertions run on every cycle and cover the pin-level rules for each decoded role. An address-role half must carry its address slice. An input half must never drive. An open-drain output must never drive a 1. The handshake must keep the two directions aligned. The float request must silence the address pins, and the timing flag must never rise outside reset. The reset values for each strap setting, the data writes limited to output halves, the one-cycle delay on the input capture and the exact register readback depend on the register history. Only the bench's reference model shows these, cycle by cycle, across its scripted and random scenarios.

// File: rtl/addr_io_pkg.sv
package addr_io_pkg;

    localparam int NIB_W   = 4;
    localparam int NIB_CNT = 2;
    localparam int PORT_W  = NIB_W * NIB_CNT;

    // mode register bit positions
    localparam int MB_OD      = 4;
    localparam int MB_EXT_CLR = 5;
    localparam int MB_HS      = 6;
    localparam int MB_HIZ     = 7;

    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_MODE = 1'b1;

    typedef enum logic [1:0] {
        ROLE_IN   = 2'b00,
        ROLE_OUT  = 2'b01,
        ROLE_ADDR = 2'b10
    } role_t;

    typedef struct packed {
        logic [1:0]        lo_code;
        logic [1:0]        hi_code;
        logic              od;
        logic              hs_en;
        logic              hiz_req;
        logic              ext;
        logic [PORT_W-1:0] dout;
        logic [PORT_W-1:0] din;
    } port_state_t;

    function automatic role_t code_to_role(input logic [1:0] code);
        case (code)
            2'b01:   return ROLE_OUT;
            2'b10:   return ROLE_ADDR;
            default: return ROLE_IN;
        endcase
    endfunction

endpackage

// File: rtl/addr_io_role_dec.sv
module addr_io_role_dec
    import addr_io_pkg::*;
(
    input  logic [1:0] lo_code,
    input  logic [1:0] hi_code,
    input  logic       hs_en,
    output role_t      role_lo,
    output role_t      role_hi,
    output logic       hs_active,
    output logic       hs_dir_out
);
    role_t raw_lo;
    role_t raw_hi;

    always_comb begin
        raw_lo     = code_to_role(lo_code);
        raw_hi     = code_to_role(hi_code);
        hs_active  = hs_en && (raw_hi != ROLE_ADDR);
        hs_dir_out = hs_active && (raw_hi == ROLE_OUT);
        role_hi    = raw_hi;
        role_lo    = (hs_active && raw_lo != ROLE_ADDR) ? raw_hi : raw_lo;
    end
endmodule

// File: rtl/addr_io_nib_drv.sv
module addr_io_nib_drv
    import addr_io_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  role_t        role,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] din,
    input  logic         od,
    input  logic         hiz,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] rd
);
    always_comb begin
        case (role)
            ROLE_ADDR: begin
                pad_out = addr;
                pad_oe  = hiz ? '0 : '1;
                rd      = din;
            end
            ROLE_OUT: begin
                pad_out = dout;
                pad_oe  = od ? ~dout : '1;
                rd      = dout;
            end
            default: begin
                pad_out = '0;
                pad_oe  = '0;
                rd      = din;
            end
        endcase
    end
endmodule

// File: rtl/addr_io_port.sv
module addr_io_port
    import addr_io_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_romless,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        pad_in,
    output logic [7:0]        pad_out,
    output logic [7:0]        pad_oe,
    output logic              open_drain,
    output logic              ext_timing,
    output logic              hs_active,
    output logic              hs_dir_out,
    output logic              bus_hiz
);
    localparam int ADDR_BASE = ADDR_W - PORT_W;

    port_state_t st_q, st_d;
    role_t       role_lo, role_hi;
    role_t       role_eff [NIB_CNT];
    logic [PORT_W-1:0] rd_bits;

    function automatic port_state_t reset_state(input logic romless);
        port_state_t s;
        s         = '0;
        s.lo_code = romless ? 2'b10 : 2'b00;
        s.hi_code = romless ? 2'b10 : 2'b00;
        s.ext     = romless;
        return s;
    endfunction

    addr_io_role_dec u_dec (
        .lo_code    (st_q.lo_code),
        .hi_code    (st_q.hi_code),
        .hs_en      (st_q.hs_en),
        .role_lo    (role_lo),
        .role_hi    (role_hi),
        .hs_active  (hs_active),
        .hs_dir_out (hs_dir_out)
    );

    assign role_eff[0] = role_lo;
    assign role_eff[1] = role_hi;
    assign bus_hiz     = st_q.hiz_req && (role_lo == ROLE_ADDR || role_hi == ROLE_ADDR);

    for (genvar g = 0; g < NIB_CNT; g++) begin : g_nib
        addr_io_nib_drv #(.W(NIB_W)) u_drv (
            .role    (role_eff[g]),
            .dout    (st_q.dout[g*NIB_W +: NIB_W]),
            .addr    (mem_addr[ADDR_BASE + g*NIB_W +: NIB_W]),
            .din     (st_q.din[g*NIB_W +: NIB_W]),
            .od      (st_q.od),
            .hiz     (bus_hiz),
            .pad_out (pad_out[g*NIB_W +: NIB_W]),
            .pad_oe  (pad_oe[g*NIB_W +: NIB_W]),
            .rd      (rd_bits[g*NIB_W +: NIB_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.din = pad_in;
        if (reg_wr) begin
            if (reg_sel == SEL_MODE) begin
                st_d.lo_code = reg_wdata[1:0];
                st_d.hi_code = reg_wdata[3:2];
                st_d.od      = reg_wdata[MB_OD];
                st_d.hs_en   = reg_wdata[MB_HS];
                st_d.hiz_req = reg_wdata[MB_HIZ];
                if (reg_wdata[MB_EXT_CLR]) begin
                    st_d.ext = 1'b0;
                end
            end else begin
                for (int n = 0; n < NIB_CNT; n++) begin
                    if (role_eff[n] == ROLE_OUT) begin
                        st_d.dout[n*NIB_W +: NIB_W] = reg_wdata[n*NIB_W +: NIB_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state(strap_romless);
        end else begin
            st_q <= st_d;
        end
    end

    assign open_drain = st_q.od;
    assign ext_timing = st_q.ext;
    assign reg_rdata  = (reg_sel == SEL_MODE)
                      ? {st_q.hiz_req, st_q.hs_en, st_q.ext, st_q.od, st_q.hi_code, st_q.lo_code}
                      : rd_bits;
endmodule

// File: rtl/addr_io_port_chk.sv
module addr_io_port_chk
    import addr_io_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input role_t             role_lo,
    input role_t             role_hi,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        pad_out,
    input logic [7:0]        pad_oe,
    input logic              open_drain,
    input logic              ext_timing,
    input logic              hs_active,
    input logic              bus_hiz
);
    localparam int AB = ADDR_W - 8;

    AST_LO_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (role_lo == ROLE_ADDR && !bus_hiz) |-> (pad_out[3:0] == mem_addr[AB +: 4] && pad_oe[3:0] == 4'hF)); // R4
    AST_HI_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (role_hi == ROLE_ADDR && !bus_hiz) |-> (pad_out[7:4] == mem_addr[AB+4 +: 4] && pad_oe[7:4] == 4'hF)); // R4
    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (role_lo == ROLE_IN) |-> (pad_oe[3:0] == 4'h0)); // R3
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (open_drain && role_hi == ROLE_OUT) |-> ((pad_oe[7:4] & pad_out[7:4]) == 4'h0)); // R8
    AST_HS_SAME_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        hs_active |-> (role_lo == ROLE_ADDR || role_lo == role_hi)); // R9
    AST_HIZ_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hiz |-> (role_lo == ROLE_ADDR || role_hi == ROLE_ADDR)); // R10
    AST_HIZ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hiz && role_lo == ROLE_ADDR) |-> (pad_oe[3:0] == 4'h0)); // R10
    AST_EXT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ext_timing)); // R7
endmodule

bind addr_io_port addr_io_port_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .role_lo    (role_lo),
    .role_hi    (role_hi),
    .mem_addr   (mem_addr),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .open_drain (open_drain),
    .ext_timing (ext_timing),
    .hs_active  (hs_active),
    .bus_hiz    (bus_hiz)
);

// File: tb/addr_io_port_tb_top.sv
`timescale 1ns/1ps
module addr_io_port_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        strap_romless = 1;
    logic        reg_wr = 0;
    logic        reg_sel = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic [15:0] mem_addr = 0;
    logic [7:0]  pad_in = 0;
    logic [7:0]  pad_out, pad_oe;
    logic        open_drain, ext_timing, hs_active, hs_dir_out, bus_hiz;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #4 clk = ~clk;

    addr_io_port dut_i (
        .clk(clk), .rst_n(rst_n), .strap_romless(strap_romless),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_addr(mem_addr), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .open_drain(open_drain), .ext_timing(ext_timing), .hs_active(hs_active),
        .hs_dir_out(hs_dir_out), .bus_hiz(bus_hiz)
    );

    // behavioural reference model
    int       m_lo_code, m_hi_code;
    bit       m_od, m_hs, m_hiz, m_ext;
    bit [7:0] m_out, m_in;
    int       r_lo, r_hi;   // 0 in, 1 out, 2 addr
    bit       e_hsa, e_hsd, e_hiz;

    function automatic int eff(int c);
        return (c == 1) ? 1 : (c == 2) ? 2 : 0;
    endfunction

    task automatic model_reset();
        m_lo_code = strap_romless ? 2 : 0;
        m_hi_code = m_lo_code;
        m_ext = strap_romless;
        m_od = 0; m_hs = 0; m_hiz = 0; m_out = 0; m_in = 0;
    endtask

    task automatic model_roles();
        r_hi  = eff(m_hi_code);
        r_lo  = eff(m_lo_code);
        e_hsa = m_hs && (r_hi != 2);
        if (e_hsa && r_lo != 2) r_lo = r_hi;
        e_hsd = e_hsa && (r_hi == 1);
        e_hiz = m_hiz && (r_lo == 2 || r_hi == 2);
    endtask

    task automatic compare(input string tag);
        bit [7:0] x_out, x_oe, x_rd;
        bit [3:0] a, o;
        int r;
        model_roles();
        for (int n = 0; n < 2; n++) begin
            r = (n == 0) ? r_lo : r_hi;
            a = mem_addr[8 + 4*n +: 4];
            o = m_out[4*n +: 4];
            if (r == 2) begin
                x_out[4*n +: 4] = a; x_oe[4*n +: 4] = e_hiz ? 4'h0 : 4'hF; x_rd[4*n +: 4] = m_in[4*n +: 4];
            end else if (r == 1) begin
                x_out[4*n +: 4] = o; x_oe[4*n +: 4] = m_od ? ~o : 4'hF; x_rd[4*n +: 4] = o;
            end else begin
                x_out[4*n +: 4] = 0; x_oe[4*n +: 4] = 0; x_rd[4*n +: 4] = m_in[4*n +: 4];
            end
        end
        if (reg_sel)
            x_rd = {m_hiz, m_hs, m_ext, m_od, 2'(m_hi_code), 2'(m_lo_code)};
        n_checks++;
        if (pad_out !== x_out || pad_oe !== x_oe || reg_rdata !== x_rd || open_drain !== m_od ||
            ext_timing !== m_ext || hs_active !== e_hsa || hs_dir_out !== e_hsd || bus_hiz !== e_hiz) begin
            n_fail++;
            $display("FAIL %s: out=%h oe=%h rd=%h od=%b ext=%b hsa=%b hsd=%b hiz=%b expected out=%h oe=%h rd=%h od=%b ext=%b hsa=%b hsd=%b hiz=%b",
                     tag, pad_out, pad_oe, reg_rdata, open_drain, ext_timing, hs_active, hs_dir_out, bus_hiz,
                     x_out, x_oe, x_rd, m_od, m_ext, e_hsa, e_hsd, e_hiz);
        end
    endtask

    task automatic model_edge();
        model_roles();
        if (reg_wr) begin
            if (reg_sel) begin
                m_lo_code = reg_wdata[1:0];
                m_hi_code = reg_wdata[3:2];
                m_od  = reg_wdata[4];
                m_hs  = reg_wdata[6];
                m_hiz = reg_wdata[7];
                if (reg_wdata[5]) m_ext = 0;
            end else begin
                if (r_lo == 1) m_out[3:0] = reg_wdata[3:0];
                if (r_hi == 1) m_out[7:4] = reg_wdata[7:4];
            end
        end
        m_in = pad_in;
    endtask

    // call right after a falling edge with inputs already set
    task automatic step(input string tag);
        #1;
        if (!rst_n) model_reset();
        compare(tag);
        @(posedge clk);
        if (rst_n) model_edge();
        else model_reset();
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        reg_wr = 0;
        step(tag);
    endtask

    task automatic wmode(input bit [7:0] v, input string tag);
        reg_wr = 1; reg_sel = 1; reg_wdata = v;
        step(tag);
        reg_wr = 0;
    endtask

    task automatic wdata(input bit [7:0] v, input string tag);
        reg_wr = 1; reg_sel = 0; reg_wdata = v;
        step(tag);
        reg_wr = 0;
    endtask

    task automatic do_reset(input bit romless, input string tag);
        @(negedge clk);
        rst_n = 0; strap_romless = romless; reg_wr = 0;
        for (int i = 0; i < 3; i++) step(tag);
        rst_n = 1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset with external program memory
        mem_addr = 16'hA5C3;
        do_reset(1, "R1 reset romless");
        reg_sel = 1; idle("R1 mode readback after reset");
        reg_sel = 0;
        mem_addr = 16'h3C00; idle("R1 address tracks");
        mem_addr = 16'hF0FF; idle("R4 address both halves");

        // R4: lower address, upper output
        wmode(8'h06, "R4 lower addr upper out");
        mem_addr = 16'h0900; idle("R4 lower slice");
        wdata(8'h7B, "R5 write upper only");
        idle("R5 upper holds data");
        mem_addr = 16'h5A00; pad_in = 8'h3E; idle("R6 capture");
        idle("R6 lower reads capture");

        // R7: clearing extended timing
        wmode(8'h06, "R7 bit5 clear keeps ext");
        wmode(8'h26, "R7 bit5 set clears ext");
        reg_sel = 1; idle("R7 readback ext cleared");
        wmode(8'h06, "R7 stays cleared");

        // R2: reset for internal program memory
        do_reset(0, "R2 reset rom");
        reg_sel = 0;
        for (int i = 0; i < 4; i++) begin
            pad_in = 8'h11 * (i + 3);
            idle("R6 input sampling");
        end
        wdata(8'hFF, "R5 write ignored when input");
        idle("R5 no output change");

        // R3: both output, then reserved code
        wmode(8'h05, "R3 both output");
        wdata(8'hC6, "R5 both halves written");
        idle("R5 readback");
        wmode(8'h0F, "R3 reserved acts as input");
        wdata(8'h99, "R3 reserved not writable");
        idle("R3 reserved reads pads");
        wmode(8'h0D, "R3 lower out upper reserved");

        // R8: open drain
        wmode(8'h15, "R8 open drain both out");
        wdata(8'hA5, "R8 pattern");
        idle("R8 enables follow zeros");
        wmode(8'h16, "R8 address half unaffected");
        idle("R8 check");
        wmode(8'h05, "R8 push-pull");

        // R9: handshake
        wmode(8'h44, "R9 upper out forces lower out");
        wdata(8'h3C, "R9 lower takes write");
        idle("R9 check");
        wmode(8'h41, "R9 upper in forces lower in");
        idle("R9 check in");
        wmode(8'h48, "R9 upper addr disables handshake");
        wmode(8'h46, "R9 lower addr kept");

        // R10: high impedance
        wmode(8'h8A, "R10 both addr floated");
        mem_addr = 16'hBEEF; idle("R10 floated");
        wmode(8'h86, "R10 lower addr floated upper out");
        wmode(8'h85, "R10 no address no float");
        wmode(8'h0A, "R10 released");

        // mixed random traffic, all requirements
        for (int i = 0; i < 400; i++) begin
            reg_wr    = ($urandom % 3) == 0;
            reg_sel   = $urandom % 2;
            reg_wdata = 8'($urandom);
            pad_in    = 8'($urandom);
            mem_addr  = 16'($urandom);
            step("R3 R5 R8 R9 R10 random");
        end
        reg_wr = 0;
        do_reset(1, "R1 second reset romless");
        idle("R1 after release");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule